// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel TFT panel. From a system clock it derives a pixel strobe, and from that strobe it walks a horizontal and a vertical position counter through sync, back porch, active and front porch. From those counters it drives HSYNC, VSYNC, data enable and the pixel coordinates of the current active pixel. It also selects the 24-bit colour sent to the panel. In normal mode that colour is the incoming foreground pixel, or the background colour when no pixel is offered. Two self-generated patterns are also available: a coordinate pattern and eight vertical colour bars.

All timing and mode settings are written through a simple write port into a shadow copy. The live copy changes only when software requests a reload and the current frame ends, so a half-written configuration never reaches the panel. A missing foreground pixel during an active pixel in normal mode is recorded as an underrun. The underrun raises an interrupt unless it is masked, and software clears it by writing a one.

Top module: `lcd_raster_gen`

## Requirements
- R1: With divider register (address 0x6, bits 7:0) holding value D, `pix_en_o` is high for one system clock in every D+1 clocks. Every position counter step happens on such a clock.
- R2: Horizontal parameters (address 0x3): front porch in bits 10:0, sync width in bits 21:11, back porch in bits 31:22. Each line runs sync, back porch, active (width field × 16 pixels, address 0x2 bits 10:0), then front porch. `x_o` counts from 0 across the active pixels.
- R3: Vertical parameters (address 0x4) use the same field layout, counted in lines. The active height is in address 0x2 bits 26:16. `y_o` counts from 0 across the active lines.
- R4: `de_o` is high only while both axes are in their active region and the mode is not off. `x_o` and `y_o` read 0 whenever `de_o` is low.
- R5: Polarity register (address 0x5): bit 0 set makes HSYNC active-low, and bit 1 set makes VSYNC active-low. When a bit is clear, that sync is active-high.
- R6: Mode field (address 0x0, bits 1:0): 0 off, 1 normal, 2 test, 3 colour bars. In off mode both syncs sit at their inactive level and `de_o` stays low. Off mode, with all timing fields zero, is the reset state.
- R7: In normal mode an active pixel shows `pix_rgb_i` when `pix_valid_i` is high. Otherwise it shows the background colour from address 0x1: red in bits 23:16, green in bits 15:8, blue in bits 7:0. `rgb_o` is 0 outside data enable.
- R8: In colour-bar mode the active width is split into 8 bars, each 2 × width field pixels wide. From left to right the bars are white, yellow, cyan, green, magenta, red, blue, black.
- R9: In test mode an active pixel shows {x[7:0], y[7:0], x[7:0] xor y[7:0]}.
- R10: Writes to addresses 0x0 to 0x6 do not change the output timing or colours until bit 30 is written to address 0x9. The copy then happens at the next frame wrap, and the request clears itself after that copy.
- R11: In normal mode, an active pixel strobe with `pix_valid_i` low sets the underrun status (address 0x7, bit 1). `irq_o` is high while that status is set and mask bit 1 (address 0x8) is clear. The mask resets to 1.
- R12: Writing 1 to bit 1 of address 0x7 clears the underrun status. If a new underrun occurs in the same cycle, the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register write data |
| pix_valid_i | input | 1 | Foreground pixel available |
| pix_rgb_i | input | 24 | Foreground pixel colour |
| pix_en_o | output | 1 | Pixel strobe |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | 15 | Active pixel column |
| y_o | output | 11 | Active line number |
| rgb_o | output | 24 | Pixel colour to panel |
| irq_o | output | 1 | Underrun interrupt |

## Verification
An underrun can be set in the same cycle that software writes its clear. The bench provokes this with normal mode and a divide ratio of one, holding the pixel valid input low across active lines while it writes the clear bit on every clock. The behavioural model lets the set win, and the interrupt and status are compared every cycle. A reload request written while a frame wraps is also exercised, with the model deferring the copy to the following wrap.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  parameter int FLD_W      = 11;
  parameter int UNIT_SHIFT = 4;
  parameter int DIV_W      = 8;
  parameter int ADDR_W     = 4;
  parameter int DATA_W     = 32;
  parameter int NBARS      = 8;

  localparam int HCNT_W = FLD_W + UNIT_SHIFT + 2;
  localparam int VCNT_W = FLD_W + 2;
  localparam int XPOS_W = FLD_W + UNIT_SHIFT;
  localparam int IDX_W  = $clog2(NBARS);

  localparam logic [ADDR_W-1:0] A_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] A_BG   = 4'h1;
  localparam logic [ADDR_W-1:0] A_SIZE = 4'h2;
  localparam logic [ADDR_W-1:0] A_HPAR = 4'h3;
  localparam logic [ADDR_W-1:0] A_VPAR = 4'h4;
  localparam logic [ADDR_W-1:0] A_POL  = 4'h5;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'h6;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h7;
  localparam logic [ADDR_W-1:0] A_MASK = 4'h8;
  localparam logic [ADDR_W-1:0] A_UPD  = 4'h9;

  localparam int PW_LSB     = 11;
  localparam int BP_LSB     = 22;
  localparam int HEIGHT_LSB = 16;
  localparam int UNDRUN_BIT = 1;
  localparam int RELOAD_BIT = 30;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_TEST   = 2'd2,
    MODE_BARS   = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e             mode;
    logic [23:0]       bg;
    logic [FLD_W-1:0]  width_u;
    logic [FLD_W-1:0]  height;
    logic [FLD_W-1:0]  hpw;
    logic [FLD_W-1:0]  hbp;
    logic [FLD_W-1:0]  hfp;
    logic [FLD_W-1:0]  vpw;
    logic [FLD_W-1:0]  vbp;
    logic [FLD_W-1:0]  vfp;
    logic              pol_h;
    logic              pol_v;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  function automatic logic [23:0] bar_colour(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    bar_colour = 24'hFFFFFF;
      3'd1:    bar_colour = 24'hFFFF00;
      3'd2:    bar_colour = 24'h00FFFF;
      3'd3:    bar_colour = 24'h00FF00;
      3'd4:    bar_colour = 24'hFF00FF;
      3'd5:    bar_colour = 24'hFF0000;
      3'd6:    bar_colour = 24'h0000FF;
      default: bar_colour = 24'h000000;
    endcase
  endfunction
endpackage

// File: rtl/lcd_raster_regs.sv
module lcd_raster_regs
  import lcd_raster_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              frame_start_i,
  input  logic              underrun_i,
  output cfg_t              cfg_o,
  output logic              irq_o
);
  cfg_t shadow_q, cfg_q;
  logic pend_q, stat_q, mask_q;
  logic wr_reload, wr_clear;
  logic unused_wdata;

  assign unused_wdata = ^wr_data_i;
  assign wr_reload = wr_en_i && (wr_addr_i == A_UPD)  && wr_data_i[RELOAD_BIT];
  assign wr_clear  = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[UNDRUN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MODE: shadow_q.mode <= mode_e'(wr_data_i[1:0]);
        A_BG:   shadow_q.bg   <= wr_data_i[23:0];
        A_SIZE: begin
          shadow_q.height  <= wr_data_i[HEIGHT_LSB +: FLD_W];
          shadow_q.width_u <= wr_data_i[0 +: FLD_W];
        end
        A_HPAR: begin
          shadow_q.hbp <= FLD_W'(wr_data_i[DATA_W-1:BP_LSB]);
          shadow_q.hpw <= wr_data_i[PW_LSB +: FLD_W];
          shadow_q.hfp <= wr_data_i[0 +: FLD_W];
        end
        A_VPAR: begin
          shadow_q.vbp <= FLD_W'(wr_data_i[DATA_W-1:BP_LSB]);
          shadow_q.vpw <= wr_data_i[PW_LSB +: FLD_W];
          shadow_q.vfp <= wr_data_i[0 +: FLD_W];
        end
        A_POL: begin
          shadow_q.pol_h <= wr_data_i[0];
          shadow_q.pol_v <= wr_data_i[1];
        end
        A_DIV:  shadow_q.div <= wr_data_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // live copy follows shadow only on a requested frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (pend_q && frame_start_i) cfg_q <= shadow_q;
      pend_q <= (pend_q && !frame_start_i) || wr_reload;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      stat_q <= underrun_i || (stat_q && !wr_clear);
      if (wr_en_i && wr_addr_i == A_MASK) mask_q <= wr_data_i[UNDRUN_BIT];
    end
  end

  assign cfg_o = cfg_q;
  assign irq_o = stat_q && !mask_q;

  p_cfg_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && frame_start_i) |=> $stable(cfg_q));
  p_reload_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && frame_start_i && !wr_reload) |=> !pend_q);
  p_underrun_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_i |=> stat_q);
  p_status_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !wr_clear) |=> stat_q);
endmodule

// File: rtl/lcd_raster_axis.sv
module lcd_raster_axis
  import lcd_raster_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int POS_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [FLD_W-1:0] pw_i,
  input  logic [FLD_W-1:0] bp_i,
  input  logic [FLD_W-1:0] fp_i,
  input  logic [CNT_W-1:0] act_i,
  output logic             last_o,
  output logic             sync_o,
  output logic             act_o,
  output logic [POS_W-1:0] pos_o
);
  logic [CNT_W-1:0] cnt_q, tot, last_val, act_start;

  assign act_start = CNT_W'(pw_i) + CNT_W'(bp_i);
  assign tot       = act_start + act_i + CNT_W'(fp_i);
  assign last_val  = (tot == '0) ? '0 : tot - CNT_W'(1);
  assign last_o    = cnt_q >= last_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  // order: sync, back porch, active, front porch
  assign sync_o = cnt_q < CNT_W'(pw_i);
  assign act_o  = (cnt_q >= act_start) && (cnt_q < act_start + act_i);
  assign pos_o  = act_o ? POS_W'(cnt_q - act_start) : '0;

  // R2 for the line counter, R3 for the frame counter
  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_val);
endmodule

// File: rtl/lcd_raster_pixel.sv
module lcd_raster_pixel
  import lcd_raster_pkg::*;
(
  input  mode_e             mode_i,
  input  logic [23:0]       bg_i,
  input  logic [FLD_W-1:0]  width_u_i,
  input  logic              de_i,
  input  logic [XPOS_W-1:0] x_i,
  input  logic [7:0]        y_lo_i,
  input  logic              pix_valid_i,
  input  logic [23:0]       pix_rgb_i,
  output logic [23:0]       rgb_o
);
  logic [XPOS_W-1:0] thr [NBARS];
  logic [IDX_W-1:0]  idx;

  // bar k starts at k * (active width / NBARS)
  for (genvar g = 0; g < NBARS; g++) begin : g_thr
    assign thr[g] = XPOS_W'(g) * XPOS_W'({width_u_i, 1'b0});
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k < NBARS; k++)
      if (x_i >= thr[k]) idx = idx + IDX_W'(1);
  end

  always_comb begin
    rgb_o = '0;
    if (de_i) begin
      case (mode_i)
        MODE_NORMAL: rgb_o = pix_valid_i ? pix_rgb_i : bg_i;
        MODE_TEST:   rgb_o = {x_i[7:0], y_lo_i, x_i[7:0] ^ y_lo_i};
        MODE_BARS:   rgb_o = bar_colour(idx);
        default:     rgb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              pix_valid_i,
  input  logic [23:0]       pix_rgb_i,
  output logic              pix_en_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [14:0]       x_o,
  output logic [10:0]       y_o,
  output logic [23:0]       rgb_o,
  output logic              irq_o
);
  cfg_t              cfg;
  logic [DIV_W-1:0]  dcnt_q;
  logic              pix_en, frame_start, underrun, on;
  logic              h_last, h_sync, h_act, v_last, v_sync, v_act;
  logic [XPOS_W-1:0] h_pos;
  logic [FLD_W-1:0]  v_pos;

  lcd_raster_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .frame_start_i (frame_start),
    .underrun_i    (underrun),
    .cfg_o         (cfg),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dcnt_q <= '0;
    else         dcnt_q <= pix_en ? '0 : dcnt_q + DIV_W'(1);
  end
  assign pix_en = dcnt_q >= cfg.div;

  lcd_raster_axis #(.CNT_W(HCNT_W), .POS_W(XPOS_W)) u_haxis (
    .clk_i, .rst_ni,
    .step_i (pix_en),
    .pw_i   (cfg.hpw), .bp_i (cfg.hbp), .fp_i (cfg.hfp),
    .act_i  (HCNT_W'({cfg.width_u, {UNIT_SHIFT{1'b0}}})),
    .last_o (h_last), .sync_o (h_sync), .act_o (h_act), .pos_o (h_pos)
  );

  lcd_raster_axis #(.CNT_W(VCNT_W), .POS_W(FLD_W)) u_vaxis (
    .clk_i, .rst_ni,
    .step_i (pix_en && h_last),
    .pw_i   (cfg.vpw), .bp_i (cfg.vbp), .fp_i (cfg.vfp),
    .act_i  (VCNT_W'(cfg.height)),
    .last_o (v_last), .sync_o (v_sync), .act_o (v_act), .pos_o (v_pos)
  );

  assign frame_start = pix_en && h_last && v_last;
  assign on          = cfg.mode != MODE_OFF;
  assign de_o        = on && h_act && v_act;
  assign hsync_o     = (on && h_sync) ^ cfg.pol_h;
  assign vsync_o     = (on && v_sync) ^ cfg.pol_v;
  assign x_o         = de_o ? h_pos : '0;
  assign y_o         = de_o ? v_pos : '0;
  assign pix_en_o    = pix_en;
  assign underrun    = pix_en && de_o && (cfg.mode == MODE_NORMAL) && !pix_valid_i;

  lcd_raster_pixel u_pixel (
    .mode_i      (cfg.mode),
    .bg_i        (cfg.bg),
    .width_u_i   (cfg.width_u),
    .de_i        (de_o),
    .x_i         (x_o),
    .y_lo_i      (y_o[7:0]),
    .pix_valid_i,
    .pix_rgb_i,
    .rgb_o
  );

  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_o && cfg.div != '0 && !frame_start) |=> !pix_en_o);
  p_de_outside_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o == cfg.pol_h && vsync_o == cfg.pol_v));
  p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == MODE_OFF) |-> (hsync_o == cfg.pol_h && vsync_o == cfg.pol_v && !de_o));
  p_blank_black_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (rgb_o == '0 && x_o == '0 && y_o == '0));
endmodule

// File: tb/lcd_raster_gen_bench.sv
`timescale 1ns/1ps
module lcd_raster_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        pix_valid_i = 1'b1;
  logic [23:0] pix_rgb_i = '0;
  logic        pix_en_o, hsync_o, vsync_o, de_o, irq_o;
  logic [14:0] x_o;
  logic [10:0] y_o;
  logic [23:0] rgb_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int valid_mode = 0;  // 0 high, 1 random, 2 low

  always #2.5 clk = ~clk;  // 200 MHz

  lcd_raster_gen u_lcd_raster_gen (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .pix_valid_i, .pix_rgb_i, .pix_en_o, .hsync_o, .vsync_o,
    .de_o, .x_o, .y_o, .rgb_o, .irq_o
  );

  // model state: index map of configuration words
  localparam int M_MODE = 0, M_BG = 1, M_WU = 2, M_HT = 3, M_HPW = 4, M_HBP = 5,
                 M_HFP = 6, M_VPW = 7, M_VBP = 8, M_VFP = 9, M_PH = 10, M_PV = 11,
                 M_DIV = 12, M_N = 13;
  int sh [M_N];
  int wk [M_N];
  int dcnt, h, v, st, mk, pend;

  task automatic model_reset();
    for (int i = 0; i < M_N; i++) begin sh[i] = 0; wk[i] = 0; end
    dcnt = 0; h = 0; v = 0; st = 0; mk = 1; pend = 0;
  endtask

  function automatic int bar_col(input int i);
    case (i)
      0: return 32'hFFFFFF; 1: return 32'hFFFF00; 2: return 32'h00FFFF;
      3: return 32'h00FF00; 4: return 32'hFF00FF; 5: return 32'hFF0000;
      6: return 32'h0000FF; default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  initial model_reset();

  always @(negedge clk) begin
    if (!rst_ni) begin
      model_reset();
      // R6: reset is off mode with quiet syncs
      chk("R6", "hsync in reset", int'(hsync_o), 0);
      chk("R6", "vsync in reset", int'(vsync_o), 0);
      chk("R6", "de in reset", int'(de_o), 0);
      chk("R11", "irq in reset", int'(irq_o), 0);
    end else begin
      int hoff, hact, htot, hlast, voff, vact, vtot, vlast;
      int pe, hl, vl, fs, on, ha, va, e_de, e_hs, e_vs, e_x, e_y, e_rgb, e_irq, urun;
      int sh_old [M_N];
      string rtag;
      hoff = wk[M_HPW] + wk[M_HBP]; hact = wk[M_WU] * 16;
      htot = hoff + hact + wk[M_HFP]; hlast = (htot == 0) ? 0 : htot - 1;
      voff = wk[M_VPW] + wk[M_VBP]; vact = wk[M_HT];
      vtot = voff + vact + wk[M_VFP]; vlast = (vtot == 0) ? 0 : vtot - 1;
      pe = (dcnt >= wk[M_DIV]); hl = (h >= hlast); vl = (v >= vlast);
      fs = pe && hl && vl;
      on = (wk[M_MODE] != 0);
      ha = (h >= hoff) && (h < hoff + hact);
      va = (v >= voff) && (v < voff + vact);
      e_de = on && ha && va;
      e_hs = (on && (h < wk[M_HPW])) ^ wk[M_PH];
      e_vs = (on && (v < wk[M_VPW])) ^ wk[M_PV];
      e_x = e_de ? h - hoff : 0;
      e_y = e_de ? v - voff : 0;
      e_rgb = 0; rtag = "R7";
      if (e_de) begin
        case (wk[M_MODE])
          1: e_rgb = pix_valid_i ? int'(pix_rgb_i) : wk[M_BG];
          2: begin rtag = "R9"; e_rgb = ((e_x & 255) << 16) | ((e_y & 255) << 8) | ((e_x ^ e_y) & 255); end
          3: begin rtag = "R8"; e_rgb = bar_col(e_x / (wk[M_WU] * 2)); end
          default: e_rgb = 0;
        endcase
      end
      e_irq = st && !mk;

      chk("R1", "pix_en", int'(pix_en_o), pe);
      chk("R2 R5 R6 R10", "hsync", int'(hsync_o), e_hs);
      chk("R3 R5 R6 R10", "vsync", int'(vsync_o), e_vs);
      chk("R4", "de", int'(de_o), e_de);
      chk("R2", "x", int'(x_o), e_x);
      chk("R3", "y", int'(y_o), e_y);
      chk(rtag, "rgb", int'(rgb_o), e_rgb);
      chk("R11 R12", "irq", int'(irq_o), e_irq);

      // advance the model to the next edge
      urun = pe && e_de && (wk[M_MODE] == 1) && !pix_valid_i;
      for (int i = 0; i < M_N; i++) sh_old[i] = sh[i];
      if (pend && fs) for (int i = 0; i < M_N; i++) wk[i] = sh_old[i];
      pend = pend && !fs;
      if (wr_en_i) begin
        case (wr_addr_i)
          4'h0: sh[M_MODE] = int'(wr_data_i[1:0]);
          4'h1: sh[M_BG] = int'(wr_data_i[23:0]);
          4'h2: begin sh[M_WU] = int'(wr_data_i[10:0]); sh[M_HT] = int'(wr_data_i[26:16]); end
          4'h3: begin sh[M_HFP] = int'(wr_data_i[10:0]); sh[M_HPW] = int'(wr_data_i[21:11]); sh[M_HBP] = int'(wr_data_i[31:22]); end
          4'h4: begin sh[M_VFP] = int'(wr_data_i[10:0]); sh[M_VPW] = int'(wr_data_i[21:11]); sh[M_VBP] = int'(wr_data_i[31:22]); end
          4'h5: begin sh[M_PH] = int'(wr_data_i[0]); sh[M_PV] = int'(wr_data_i[1]); end
          4'h6: sh[M_DIV] = int'(wr_data_i[7:0]);
          4'h7: if (wr_data_i[1]) st = 0;
          4'h8: mk = int'(wr_data_i[1]);
          4'h9: if (wr_data_i[30]) pend = 1;
          default: ;
        endcase
      end
      if (urun) st = 1;  // R12: set beats clear
      if (pe) begin
        dcnt = 0;
        if (hl) begin h = 0; v = vl ? 0 : v + 1; end
        else h = h + 1;
      end else dcnt = dcnt + 1;
    end
  end

  always @(posedge clk) begin
    #1;
    pix_rgb_i <= 24'($urandom);
    case (valid_mode)
      0: pix_valid_i <= 1'b1;
      1: pix_valid_i <= ($urandom % 7) != 0;
      default: pix_valid_i <= 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] par(input int bp, input int pw, input int fp);
    return (32'(bp) << 22) | (32'(pw) << 11) | 32'(fp);
  endfunction

  initial begin
    #1 rst_ni = 1'b0;
    run(4);
    rst_ni = 1'b1;
    run(3);

    // R1 R2 R3 R7 R10: first configuration, divide by two, normal mode
    wr(4'h6, 32'd1);
    wr(4'h2, (32'd3 << 16) | 32'd1);
    wr(4'h3, par(3, 2, 2));
    wr(4'h4, par(1, 1, 1));
    wr(4'h1, 32'h123456);
    wr(4'h0, 32'd1);
    run(40);  // R10: nothing live yet
    wr(4'h9, 32'h4000_0000);
    run(600);

    // R11: random gaps, interrupt unmasked, then cleared
    valid_mode = 1;
    wr(4'h8, 32'h0);
    run(500);
    valid_mode = 0;
    run(300);
    wr(4'h7, 32'h2);  // R12
    run(50);

    // R10: shadow writes without reload leave timing untouched
    wr(4'h2, (32'd3 << 16) | 32'd2);
    wr(4'h5, 32'h3);
    wr(4'h6, 32'd0);
    wr(4'h0, 32'd3);
    run(600);
    // R5 R8: reload into colour bars with inverted syncs
    wr(4'h9, 32'h4000_0000);
    run(700);

    // R9: test pattern
    wr(4'h0, 32'd2);
    wr(4'h9, 32'h4000_0000);
    run(600);

    // R6: off mode with active-low syncs
    wr(4'h0, 32'd0);
    wr(4'h9, 32'h4000_0000);
    run(400);

    // R12: underrun and clear collide while valid is held low
    wr(4'h5, 32'h0);
    wr(4'h0, 32'd1);
    wr(4'h9, 32'h4000_0000);
    run(300);
    valid_mode = 2;
    for (int i = 0; i < 300; i++) wr(4'h7, 32'h2);
    valid_mode = 1;
    run(300);
    wr(4'h8, 32'h2);  // R11: masked
    run(100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule